// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block sits behind the register decode of a hot-plug capable bridge and turns one-byte commands into changes of per-slot state. Software first loads a 5-bit target register, then writes a command byte. A slot command packs three fields into the byte: a requested slot state, a power-indicator value and an attention-indicator value. The controller checks that the target exists and that the transition is allowed. It then updates the slot's fields. When a slot is disabled with its power indicator off, it models removal of the card.

Besides slot commands there are bus-speed commands and two broadcast commands. One broadcast moves every slot to power-only and the other enables every slot. A broadcast first verifies that no slot is already enabled. It then walks the slots one per clock while busy is high. Every command clears the command status bits when it starts and raises a sticky command-detected flag when it ends, whether it succeeded or failed. Software clears that flag with a write-one-to-clear pulse.

The number of slots is a parameter from 1 to 31. A second parameter tells which slots hold a card at reset.

Top module: `hp_slot_ctrl`

## Requirements
- R1: At reset, an occupied slot reads state 2 (enabled), power indicator 1 (on), MRL closed (0) and presence 0. An empty slot reads state 3 (disabled), power indicator 3 (off), MRL open (1) and presence 3. All attention indicators, event latches, status bits, busy and command-detected read 0.
- R2: Codes 0x00–0x3F are slot commands on slot index target−1. Bits [1:0] hold the requested state (0 none, 1 power-only, 2 enabled, 3 disabled). Bits [3:2] hold the power indicator and bits [5:4] the attention indicator (0 keep, 1 on, 2 blink, 3 off). A nonzero indicator value is stored and 0 leaves the field as it was. The results show one clock after the edge that captures the command write.
- R3: A slot command whose target is 0, or whose target−1 is not below the slot count, sets invalid-command and changes no slot.
- R4: A request for power-only on an enabled slot sets invalid-command and changes nothing, including both indicators.
- R5: The state changes only from disabled to power-only or enabled, and from enabled or power-only to disabled. Any other request leaves the state as it is.
- R6: When a slot becomes disabled and its power indicator reads off after the command, the block sets MRL open and presence 3. It also latches the button, MRL and presence events of that slot.
- R7: Codes 0x40–0x47 are speed commands. Low bits 0 are accepted, and any other value sets invalid-mode.
- R8: Every code not covered by R2, R7 or R10 sets invalid-command.
- R9: Each command clears invalid-command and invalid-mode when it starts, and sets command-detected when it completes. A clear pulse resets command-detected, but a completion in the same cycle wins.
- R10: Codes 0x48 (all power-only) and 0x49 (all enabled) set invalid-command without touching any slot if any slot is enabled.
- R11: An accepted broadcast holds busy high for exactly one cycle per slot, visiting slots in ascending order. A slot with MRL closed gets the broadcast state with the power indicator on. A slot with MRL open gets no state request and the power indicator off. Command-detected is set when the walk ends.
- R12: A command write while busy is high, or while a command is still pending, is ignored.
- R13: A clear pulse on a slot's event-clear bit resets its three event latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tgt_we_i | input | 1 | Load the target register |
| tgt_i | input | 5 | Target slot number (1-based) |
| cmd_we_i | input | 1 | Command byte write strobe |
| cmd_i | input | 8 | Command byte |
| det_clr_i | input | 1 | Clear command-detected |
| ev_clr_i | input | N_SLOTS | Per-slot clear of event latches |
| state_o | output | 2*N_SLOTS | Slot states, slot s at [2s+1:2s] |
| pwr_led_o | output | 2*N_SLOTS | Power indicators |
| attn_led_o | output | 2*N_SLOTS | Attention indicators |
| mrl_open_o | output | N_SLOTS | MRL open per slot |
| presence_o | output | 2*N_SLOTS | Presence codes |
| ev_button_o | output | N_SLOTS | Latched button event |
| ev_mrl_o | output | N_SLOTS | Latched MRL event |
| ev_presence_o | output | N_SLOTS | Latched presence event |
| busy_o | output | 1 | Broadcast walk in progress |
| inv_cmd_o | output | 1 | Invalid command status |
| inv_mode_o | output | 1 | Invalid mode status |
| cmd_det_o | output | 1 | Sticky command-detected flag |

## Verification
The command byte is captured on the first edge, and slot commands, speed commands, invalid codes and failed broadcasts show their results after the second edge. The bench drives on falling edges and checks on the falling edge after that second rising edge. An accepted broadcast raises busy after the second edge and finishes N_SLOTS edges later. The bench checks busy and the cleared detect flag right after the start, and checks the slot fields and the flag after exactly N_SLOTS more edges. Event and flag clears act on the next edge and are checked on the falling edge that follows.

// File: rtl/hp_slot_pkg.sv
`timescale 1ns/1ps
package hp_slot_pkg;

    typedef enum logic [1:0] {
        ST_NONE = 2'd0,
        ST_PWR  = 2'd1,
        ST_EN   = 2'd2,
        ST_DIS  = 2'd3
    } slot_st_e;

    typedef enum logic [1:0] {
        LED_KEEP  = 2'd0,
        LED_ON    = 2'd1,
        LED_BLINK = 2'd2,
        LED_OFF   = 2'd3
    } led_e;

    typedef enum logic [2:0] {
        K_SLOT,
        K_SPEED,
        K_BC_PWR,
        K_BC_EN,
        K_BAD
    } cmd_kind_e;

    localparam logic [1:0] PRS_EMPTY = 2'd3;
    localparam logic [1:0] PRS_LOW   = 2'd0;

    typedef struct packed {
        slot_st_e   st;
        led_e       pwr;
        led_e       attn;
        logic       mrl_open;
        logic [1:0] prs;
        logic       ev_btn;
        logic       ev_mrl;
        logic       ev_prs;
    } slot_rec_t;

endpackage

// File: rtl/hp_cmd_decode.sv
`timescale 1ns/1ps
module hp_cmd_decode
    import hp_slot_pkg::*;
(
    input  logic [7:0] code_i,
    output cmd_kind_e  kind_o,
    output slot_st_e   st_o,
    output led_e       pwr_o,
    output led_e       attn_o,
    output logic       speed_bad_o
);
    always_comb begin
        st_o        = slot_st_e'(code_i[1:0]);
        pwr_o       = led_e'(code_i[3:2]);
        attn_o      = led_e'(code_i[5:4]);
        speed_bad_o = |code_i[2:0];
        if (code_i[7:6] == 2'b00)
            kind_o = K_SLOT;
        else if (code_i[7:3] == 5'b01000)
            kind_o = K_SPEED;
        else if (code_i == 8'h48)
            kind_o = K_BC_PWR;
        else if (code_i == 8'h49)
            kind_o = K_BC_EN;
        else
            kind_o = K_BAD;
    end
endmodule

// File: rtl/hp_slot_next.sv
`timescale 1ns/1ps
module hp_slot_next
    import hp_slot_pkg::*;
(
    input  slot_rec_t cur_i,
    input  slot_st_e  req_st_i,
    input  led_e      req_pwr_i,
    input  led_e      req_attn_i,
    output slot_rec_t nxt_o,
    output logic      illegal_o
);
    always_comb begin
        illegal_o = (cur_i.st == ST_EN) && (req_st_i == ST_PWR);
        nxt_o     = cur_i;
        if (req_pwr_i != LED_KEEP)
            nxt_o.pwr = req_pwr_i;
        if (req_attn_i != LED_KEEP)
            nxt_o.attn = req_attn_i;
        if (cur_i.st == ST_DIS && (req_st_i == ST_PWR || req_st_i == ST_EN)) begin
            nxt_o.st = req_st_i;
        end else if ((cur_i.st == ST_EN || cur_i.st == ST_PWR) && req_st_i == ST_DIS) begin
            nxt_o.st = ST_DIS;
            if (nxt_o.pwr == LED_OFF) begin
                nxt_o.mrl_open = 1'b1;
                nxt_o.prs      = PRS_EMPTY;
                nxt_o.ev_btn   = 1'b1;
                nxt_o.ev_mrl   = 1'b1;
                nxt_o.ev_prs   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
`timescale 1ns/1ps
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int          N_SLOTS  = 4,
    parameter logic [30:0] OCC_MASK = 31'h5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tgt_we_i,
    input  logic [4:0]             tgt_i,
    input  logic                   cmd_we_i,
    input  logic [7:0]             cmd_i,
    input  logic                   det_clr_i,
    input  logic [N_SLOTS-1:0]     ev_clr_i,
    output logic [2*N_SLOTS-1:0]   state_o,
    output logic [2*N_SLOTS-1:0]   pwr_led_o,
    output logic [2*N_SLOTS-1:0]   attn_led_o,
    output logic [N_SLOTS-1:0]     mrl_open_o,
    output logic [2*N_SLOTS-1:0]   presence_o,
    output logic [N_SLOTS-1:0]     ev_button_o,
    output logic [N_SLOTS-1:0]     ev_mrl_o,
    output logic [N_SLOTS-1:0]     ev_presence_o,
    output logic                   busy_o,
    output logic                   inv_cmd_o,
    output logic                   inv_mode_o,
    output logic                   cmd_det_o
);
    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam int TGT_W = 5;

    typedef struct packed {
        logic [7:0]       code;
        logic [TGT_W-1:0] tgt;
        logic             pend;
        logic             busy;
        logic [IDX_W-1:0] walk;
        slot_st_e         bc_st;
        logic             inv_cmd;
        logic             inv_mode;
        logic             det;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    slot_rec_t slot_d   [N_SLOTS];
    slot_rec_t slot_q   [N_SLOTS];
    slot_rec_t slot_clr [N_SLOTS];
    slot_rec_t slot_nxt [N_SLOTS];
    slot_st_e  req_st   [N_SLOTS];
    led_e      req_pwr  [N_SLOTS];
    led_e      req_attn [N_SLOTS];
    logic [N_SLOTS-1:0] illegal;
    logic [N_SLOTS-1:0] apply;

    cmd_kind_e dec_kind;
    slot_st_e  dec_st;
    led_e      dec_pwr, dec_attn;
    logic      dec_speed_bad;

    function automatic slot_rec_t reset_rec(input int s);
        slot_rec_t r;
        r = '0;
        if (OCC_MASK[s]) begin
            r.st = ST_EN;  r.pwr = LED_ON;  r.mrl_open = 1'b0; r.prs = PRS_LOW;
        end else begin
            r.st = ST_DIS; r.pwr = LED_OFF; r.mrl_open = 1'b1; r.prs = PRS_EMPTY;
        end
        r.attn = LED_KEEP;
        return r;
    endfunction

    hp_cmd_decode u_dec (
        .code_i      (ctl_q.code),
        .kind_o      (dec_kind),
        .st_o        (dec_st),
        .pwr_o       (dec_pwr),
        .attn_o      (dec_attn),
        .speed_bad_o (dec_speed_bad)
    );

    // Per-slot request, event clear and next-value logic
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        always_comb begin
            slot_clr[s] = slot_q[s];
            if (ev_clr_i[s]) begin
                slot_clr[s].ev_btn = 1'b0;
                slot_clr[s].ev_mrl = 1'b0;
                slot_clr[s].ev_prs = 1'b0;
            end
            if (ctl_q.busy) begin
                req_attn[s] = LED_KEEP;
                if (!slot_q[s].mrl_open) begin
                    req_st[s]  = ctl_q.bc_st;
                    req_pwr[s] = LED_ON;
                end else begin
                    req_st[s]  = ST_NONE;
                    req_pwr[s] = LED_OFF;
                end
            end else begin
                req_st[s]   = dec_st;
                req_pwr[s]  = dec_pwr;
                req_attn[s] = dec_attn;
            end
        end

        hp_slot_next u_next (
            .cur_i      (slot_clr[s]),
            .req_st_i   (req_st[s]),
            .req_pwr_i  (req_pwr[s]),
            .req_attn_i (req_attn[s]),
            .nxt_o      (slot_nxt[s]),
            .illegal_o  (illegal[s])
        );

        assign state_o   [2*s +: 2] = slot_q[s].st;
        assign pwr_led_o [2*s +: 2] = slot_q[s].pwr;
        assign attn_led_o[2*s +: 2] = slot_q[s].attn;
        assign presence_o[2*s +: 2] = slot_q[s].prs;
        assign mrl_open_o[s]        = slot_q[s].mrl_open;
        assign ev_button_o[s]       = slot_q[s].ev_btn;
        assign ev_mrl_o[s]          = slot_q[s].ev_mrl;
        assign ev_presence_o[s]     = slot_q[s].ev_prs;
    end

    logic [TGT_W-1:0] tgt_idx;
    logic             tgt_ok;
    logic             sel_illegal;
    logic             any_en;

    always_comb begin
        tgt_idx     = ctl_q.tgt - TGT_W'(1);
        tgt_ok      = (ctl_q.tgt != '0) && (tgt_idx < TGT_W'(N_SLOTS));
        sel_illegal = 1'b0;
        any_en      = 1'b0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (tgt_idx == TGT_W'(s)) sel_illegal = illegal[s];
            if (slot_q[s].st == ST_EN) any_en = 1'b1;
        end
    end

    always_comb begin
        ctl_d     = ctl_q;
        apply     = '0;
        ctl_d.det = ctl_q.det & ~det_clr_i;

        if (tgt_we_i)
            ctl_d.tgt = tgt_i;

        if (ctl_q.pend) begin
            ctl_d.pend     = 1'b0;
            ctl_d.inv_cmd  = 1'b0;
            ctl_d.inv_mode = 1'b0;
            unique case (dec_kind)
                K_SLOT: begin
                    if (!tgt_ok || sel_illegal) begin
                        ctl_d.inv_cmd = 1'b1;
                    end else begin
                        for (int s = 0; s < N_SLOTS; s++)
                            if (tgt_idx == TGT_W'(s)) apply[s] = 1'b1;
                    end
                    ctl_d.det = 1'b1;
                end
                K_SPEED: begin
                    ctl_d.inv_mode = dec_speed_bad;
                    ctl_d.det      = 1'b1;
                end
                K_BC_PWR, K_BC_EN: begin
                    if (any_en) begin
                        ctl_d.inv_cmd = 1'b1;
                        ctl_d.det     = 1'b1;
                    end else begin
                        ctl_d.busy  = 1'b1;
                        ctl_d.walk  = '0;
                        ctl_d.bc_st = (dec_kind == K_BC_EN) ? ST_EN : ST_PWR;
                    end
                end
                default: begin
                    ctl_d.inv_cmd = 1'b1;
                    ctl_d.det     = 1'b1;
                end
            endcase
        end

        if (ctl_q.busy) begin
            for (int s = 0; s < N_SLOTS; s++)
                if (ctl_q.walk == IDX_W'(s)) apply[s] = 1'b1;
            if (ctl_q.walk == IDX_W'(N_SLOTS - 1)) begin
                ctl_d.busy = 1'b0;
                ctl_d.det  = 1'b1;
            end else begin
                ctl_d.walk = ctl_q.walk + IDX_W'(1);
            end
        end

        if (cmd_we_i && !ctl_q.busy && !ctl_q.pend) begin
            ctl_d.code = cmd_i;
            ctl_d.pend = 1'b1;
        end

        for (int s = 0; s < N_SLOTS; s++)
            slot_d[s] = apply[s] ? slot_nxt[s] : slot_clr[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.bc_st <= ST_NONE;
            for (int s = 0; s < N_SLOTS; s++)
                slot_q[s] <= reset_rec(s);
        end else begin
            ctl_q <= ctl_d;
            for (int s = 0; s < N_SLOTS; s++)
                slot_q[s] <= slot_d[s];
        end
    end

    assign busy_o     = ctl_q.busy;
    assign inv_cmd_o  = ctl_q.inv_cmd;
    assign inv_mode_o = ctl_q.inv_mode;
    assign cmd_det_o  = ctl_q.det;

endmodule

// File: rtl/hp_slot_ctrl_chk.sv
`timescale 1ns/1ps
module hp_slot_ctrl_chk #(
    parameter int N_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2*N_SLOTS-1:0] state_o,
    input logic [2*N_SLOTS-1:0] pwr_led_o,
    input logic [2*N_SLOTS-1:0] presence_o,
    input logic [N_SLOTS-1:0]   mrl_open_o,
    input logic [N_SLOTS-1:0]   ev_mrl_o,
    input logic                 busy_o,
    input logic                 inv_cmd_o,
    input logic                 inv_mode_o,
    input logic                 cmd_det_o
);
    logic any_en;
    always_comb begin
        any_en = 1'b0;
        for (int s = 0; s < N_SLOTS; s++)
            if (state_o[2*s +: 2] == 2'd2) any_en = 1'b1;
    end

    logic [7:0] busy_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 8'd1;
        else             busy_cnt <= '0;
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_chk
        logic [1:0] st, pw, pr;
        assign st = state_o[2*s +: 2];
        assign pw = pwr_led_o[2*s +: 2];
        assign pr = presence_o[2*s +: 2];

        p_state_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(st) |->
                (($past(st) == 2'd3 && (st == 2'd1 || st == 2'd2)) ||
                 (($past(st) == 2'd2 || $past(st) == 2'd1) && st == 2'd3)));

        p_removal_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mrl_open_o[s]) |->
                (st == 2'd3 && pw == 2'd3 && pr == 2'd3 && ev_mrl_o[s]));
    end

    p_mode_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inv_mode_o) |-> cmd_det_o);

    p_status_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_cmd_o && inv_mode_o));

    p_bcast_none_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !any_en);

    p_busy_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 8'(N_SLOTS));

    p_walk_end_det_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> cmd_det_o);

endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_o    (state_o),
    .pwr_led_o  (pwr_led_o),
    .presence_o (presence_o),
    .mrl_open_o (mrl_open_o),
    .ev_mrl_o   (ev_mrl_o),
    .busy_o     (busy_o),
    .inv_cmd_o  (inv_cmd_o),
    .inv_mode_o (inv_mode_o),
    .cmd_det_o  (cmd_det_o)
);

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tgt_we = 1'b0;
    logic [4:0]   tgt = '0;
    logic         cmd_we = 1'b0;
    logic [7:0]   cmd = '0;
    logic         det_clr = 1'b0;
    logic [N-1:0] ev_clr = '0;
    logic [2*N-1:0] state, pwr, attn, prs;
    logic [N-1:0]   mrl, evb, evm, evp;
    logic busy, inv_cmd, inv_mode, det;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hp_slot_ctrl #(.N_SLOTS(N), .OCC_MASK(31'h5)) u0 (
        .clk(clk), .rst_n(rst_n), .tgt_we_i(tgt_we), .tgt_i(tgt),
        .cmd_we_i(cmd_we), .cmd_i(cmd), .det_clr_i(det_clr), .ev_clr_i(ev_clr),
        .state_o(state), .pwr_led_o(pwr), .attn_led_o(attn), .mrl_open_o(mrl),
        .presence_o(prs), .ev_button_o(evb), .ev_mrl_o(evm), .ev_presence_o(evp),
        .busy_o(busy), .inv_cmd_o(inv_cmd), .inv_mode_o(inv_mode), .cmd_det_o(det)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue target + command on one falling edge; return after the result edge.
    task automatic do_cmd(input logic [4:0] t, input logic [7:0] c);
        @(negedge clk);
        tgt = t; tgt_we = 1'b1; cmd = c; cmd_we = 1'b1;
        @(negedge clk);
        tgt_we = 1'b0; cmd_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_det();
        @(negedge clk); det_clr = 1'b1;
        @(negedge clk); det_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "state", 32'(state), 32'hEE);
        check("R1", "pwr", 32'(pwr), 32'hDD);
        check("R1", "attn", 32'(attn), 32'h0);
        check("R1", "mrl", 32'(mrl), 32'hA);
        check("R1", "presence", 32'(prs), 32'hCC);
        check("R1", "status", {evb, evm, evp, busy, inv_cmd, inv_mode, det}, 32'h0);
    endtask

    task automatic t_bad_target();
        do_cmd(5'd0, 8'h01);
        check("R3", "inv_cmd tgt0", 32'(inv_cmd), 32'h1);
        check("R9", "det after fail", 32'(det), 32'h1);
        check("R3", "state tgt0", 32'(state), 32'hEE);
        do_cmd(5'd5, 8'h03);
        check("R3", "inv_cmd tgt5", 32'(inv_cmd), 32'h1);
        check("R3", "state tgt5", 32'(state), 32'hEE);
    endtask

    task automatic t_illegal();
        do_cmd(5'd1, 8'h0D);
        check("R4", "inv_cmd", 32'(inv_cmd), 32'h1);
        check("R4", "state", 32'(state), 32'hEE);
        check("R4", "pwr", 32'(pwr), 32'hDD);
        clear_det();
        check("R9", "det cleared", 32'(det), 32'h0);
    endtask

    task automatic t_attention();
        do_cmd(5'd3, 8'h20);
        check("R2", "attn", 32'(attn), 32'h20);
        check("R2", "state kept", 32'(state), 32'hEE);
        check("R2", "pwr kept", 32'(pwr), 32'hDD);
        check("R9", "inv_cmd cleared", 32'(inv_cmd), 32'h0);
        check("R9", "det set", 32'(det), 32'h1);
    endtask

    task automatic t_speed();
        do_cmd(5'd1, 8'h40);
        check("R7", "speed0 ok", {inv_mode, inv_cmd}, 32'h0);
        do_cmd(5'd1, 8'h43);
        check("R7", "speed3 inv_mode", 32'(inv_mode), 32'h1);
        do_cmd(5'd1, 8'h50);
        check("R8", "bad code", 32'(inv_cmd), 32'h1);
        check("R9", "inv_mode cleared", 32'(inv_mode), 32'h0);
    endtask

    task automatic t_bcast_reject();
        do_cmd(5'd1, 8'h49);
        check("R10", "inv_cmd", 32'(inv_cmd), 32'h1);
        check("R10", "busy", 32'(busy), 32'h0);
        check("R10", "state", 32'(state), 32'hEE);
    endtask

    task automatic t_remove();
        do_cmd(5'd1, 8'h0F);
        check("R6", "state", 32'(state), 32'hEF);
        check("R6", "pwr", 32'(pwr), 32'hDF);
        check("R6", "mrl", 32'(mrl), 32'hB);
        check("R6", "presence", 32'(prs), 32'hCF);
        check("R6", "events", {evb, evm, evp}, {4'h1, 4'h1, 4'h1});
        do_cmd(5'd3, 8'h0B);
        check("R5", "disable keep card", 32'(state), 32'hFF);
        check("R5", "pwr blink", 32'(pwr), 32'hEF);
        check("R5", "mrl unchanged", 32'(mrl), 32'hB);
        check("R5", "events unchanged", 32'(evm), 32'h1);
        @(negedge clk); ev_clr = 4'h1;
        @(negedge clk); ev_clr = '0;
        check("R13", "events cleared", {evb, evm, evp}, 32'h0);
    endtask

    task automatic t_bcast_pwr();
        clear_det();
        do_cmd(5'd1, 8'h48);
        check("R11", "busy start", 32'(busy), 32'h1);
        check("R11", "det low mid", 32'(det), 32'h0);
        repeat (N) @(negedge clk);
        check("R11", "busy end", 32'(busy), 32'h0);
        check("R11", "det end", 32'(det), 32'h1);
        check("R11", "state", 32'(state), 32'hDF);
        check("R11", "pwr", 32'(pwr), 32'hDF);
        check("R11", "attn kept", 32'(attn), 32'h20);
    endtask

    task automatic t_ignore_busy();
        clear_det();
        do_cmd(5'd1, 8'h49);
        check("R12", "busy", 32'(busy), 32'h1);
        cmd = 8'h50; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        repeat (N - 1) @(negedge clk);
        check("R12", "ignored write", 32'(inv_cmd), 32'h0);
        check("R12", "busy end", 32'(busy), 32'h0);
        check("R11", "det end", 32'(det), 32'h1);
        check("R5", "pwr-only not enabled", 32'(state), 32'hDF);
    endtask

    task automatic t_reenable();
        do_cmd(5'd3, 8'h03);
        check("R5", "pwr-only to disabled", 32'(state), 32'hFF);
        check("R6", "no removal with pwr on", 32'(mrl), 32'hB);
        do_cmd(5'd3, 8'h06);
        check("R5", "disabled to enabled", 32'(state), 32'hEF);
        check("R2", "pwr on", 32'(pwr), 32'hDF);
        do_cmd(5'd1, 8'h48);
        check("R10", "pwr-all reject", 32'(inv_cmd), 32'h1);
        check("R10", "no walk", 32'(busy), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_target();
        t_illegal();
        t_attention();
        t_speed();
        t_bcast_reject();
        t_remove();
        t_bcast_pwr();
        t_ignore_busy();
        t_reenable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule